// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block gathers interrupt lines into banks of 32 and merges them into a single request toward the processor. Every line passes through a two-flop synchroniser. A fresh rising edge on an enabled line sets a sticky event flag. Software clears that flag by writing a one to the matching bit of the bank's acknowledge register. A fixed per-bank type mask marks some lines as level-type. For those lines the live synchronised level counts as pending, whether or not an event flag is set.

Software reads the event, enable and live-level words of each bank, decides which pending source to service, and acknowledges it. A source number n lives in bank n>>5 at bit n&31. The controller is built with one bank (32 sources) or two banks (64 sources). A cascaded secondary controller is just another input line.

Top module: `banked_irq_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every bank's event, enable and level words read 0, and `irq_req` is 0.
- R2: Bank b occupies byte addresses 0x10*b to 0x10*b+0xC. Within a bank the offsets are: 0x0 event (read-only), 0x4 enable (read/write), 0x8 acknowledge (write-only), 0xC live level (read-only). The acknowledge offset reads 0. An address whose bits [1:0] are not zero, or whose bank field is not below the bank count, reads 0 and ignores writes. Source n maps to bank n>>5, bit n&31.
- R3: A write to the enable offset replaces the whole enable word. The new value reads back from the cycle after the write.
- R4: Suppose `irq_in[n]` rises before clock edge k while enable bit n is set. The event bit then reads 1 after edge k+2: two edges for the synchroniser, one for the flag. An event bit is never set without such a fresh edge on an enabled line.
- R5: Writing 1 to a bit of the acknowledge offset clears that event bit at the write's edge. Bits written 0 are left unchanged.
- R6: If a fresh edge on an enabled line and an acknowledge of the same bit fall on the same edge, the event bit stays set.
- R7: Setting an enable bit while its input is already high sets no event flag and, for an edge-type source, raises no request.
- R8: The level offset reads the synchronised input levels of the bank, two edges behind `irq_in`.
- R9: The level-type mask is 0x3ff00000 in the one-bank build (sources 20 to 29). It is 0x1ff00000 in each bank of the two-bank build (bits 20 to 28). An enabled level-type source stays pending while its level is high, even after its event is acknowledged. An edge-type source stops being pending once acknowledged.
- R10: The pending word of a bank is (event OR (level AND type mask)) AND enable. `irq_req` is a register that equals the OR of all pending words one edge later.
- R11: Once all enable words are written 0, `irq_req` is 0 from the following edge on, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32*NUM_BANKS | Asynchronous interrupt lines, source n on bit n |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_req | output | 1 | Registered interrupt request toward the processor |

## Verification
A new rising edge can land on the same clock edge as a software acknowledge of the same bit. The bench provokes this by raising a line and issuing the acknowledge write exactly two edges later, when the synchronised edge is present. It judges the outcome by reading the event word, which must still hold the bit. A further collision, enabling a line whose input is already high, is checked by reading back both the event word and the request. A cycle-level behavioural model then runs random line activity, with random writes (unmapped and misaligned ones included), and is compared with the design on every clock.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;

    localparam int BANK_W = 32;

    // Register select inside one bank, taken from address bits [3:2].
    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    // Write command delivered to one bank.
    typedef struct packed {
        logic              en_we;
        logic              ack_we;
        logic [BANK_W-1:0] wdata;
    } bank_cmd_t;

    // State one bank shows to the bus and to the request logic.
    typedef struct packed {
        logic [BANK_W-1:0] event_q;
        logic [BANK_W-1:0] enable_q;
        logic [BANK_W-1:0] level_q;
        logic [BANK_W-1:0] pending;
    } bank_view_t;

    // Which lines of a bank are level-type, depending on the build size.
    function automatic logic [BANK_W-1:0] level_type_mask(input int num_banks);
        if (num_banks == 1)
            return 32'h3ff0_0000;
        else
            return 32'h1ff0_0000;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/irqc_bank.sv
`timescale 1ns/1ps
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [BANK_W-1:0] TYPE_MASK = 32'h1ff0_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] level_s,
    input  bank_cmd_t         cmd,
    output bank_view_t        view,
    output logic [BANK_W-1:0] rise
);
    logic [BANK_W-1:0] prev_q;
    logic [BANK_W-1:0] event_q;
    logic [BANK_W-1:0] enable_q;
    logic [BANK_W-1:0] ack_bits;
    logic [BANK_W-1:0] event_d;

    // Fresh transition relative to the previous synchronised sample.
    assign rise     = level_s & ~prev_q;
    assign ack_bits = cmd.ack_we ? cmd.wdata : '0;

    // Set term is applied after the clear term, so a same-cycle edge wins.
    always_comb begin
        event_d = (event_q & ~ack_bits) | (rise & enable_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            event_q  <= '0;
            enable_q <= '0;
        end else begin
            prev_q  <= level_s;
            event_q <= event_d;
            if (cmd.en_we)
                enable_q <= cmd.wdata;
        end
    end

    always_comb begin
        view.event_q  = event_q;
        view.enable_q = enable_q;
        view.level_q  = level_s;
        view.pending  = (event_q | (level_s & TYPE_MASK)) & enable_q;
    end
endmodule

// File: rtl/irqc_regbus.sv
`timescale 1ns/1ps
module irqc_regbus
    import irqc_pkg::*;
#(
    parameter int NB     = 2,
    parameter int ADDR_W = 8
) (
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BANK_W-1:0]    bus_wdata,
    input  bank_view_t [NB-1:0]  views,
    output bank_cmd_t  [NB-1:0]  cmds,
    output logic [BANK_W-1:0]    bus_rdata
);
    localparam int BSEL_W = ADDR_W - 4;

    logic [BSEL_W-1:0] bsel;
    reg_sel_e          rsel;
    logic              aligned;

    assign bsel    = bus_addr[ADDR_W-1:4];
    assign rsel    = reg_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar b = 0; b < NB; b++) begin : g_cmd
        logic hit;
        assign hit = aligned && (bsel == BSEL_W'(b));
        always_comb begin
            cmds[b].en_we  = bus_wr && hit && (rsel == REG_ENABLE);
            cmds[b].ack_we = bus_wr && hit && (rsel == REG_ACK);
            cmds[b].wdata  = bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (aligned && (bsel == BSEL_W'(i))) begin
                case (rsel)
                    REG_EVENT:  bus_rdata = views[i].event_q;
                    REG_ENABLE: bus_rdata = views[i].enable_q;
                    REG_ACK:    bus_rdata = '0;
                    REG_LEVEL:  bus_rdata = views[i].level_q;
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/banked_irq_ctrl.sv
`timescale 1ns/1ps
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_BANKS*BANK_W-1:0]   irq_in,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BANK_W-1:0]             bus_wdata,
    output logic [BANK_W-1:0]             bus_rdata,
    output logic                          irq_req
);
    localparam int                SRC_N     = NUM_BANKS * BANK_W;
    localparam logic [BANK_W-1:0] TYPE_MASK = level_type_mask(NUM_BANKS);

    logic [SRC_N-1:0]                 level_s;
    bank_view_t [NUM_BANKS-1:0]       views;
    bank_cmd_t  [NUM_BANKS-1:0]       cmds;
    logic [NUM_BANKS-1:0][BANK_W-1:0] ev_w;
    logic [NUM_BANKS-1:0][BANK_W-1:0] en_w;
    logic [NUM_BANKS-1:0][BANK_W-1:0] rise_w;
    logic [NUM_BANKS-1:0][BANK_W-1:0] pend_w;
    logic                             any_pending;

    irqc_sync #(.W(SRC_N)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_in),
        .sync_out (level_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqc_bank #(.TYPE_MASK(TYPE_MASK)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .level_s (level_s[b*BANK_W +: BANK_W]),
            .cmd     (cmds[b]),
            .view    (views[b]),
            .rise    (rise_w[b])
        );
        assign ev_w[b]   = views[b].event_q;
        assign en_w[b]   = views[b].enable_q;
        assign pend_w[b] = views[b].pending;
    end

    irqc_regbus #(.NB(NUM_BANKS), .ADDR_W(ADDR_W)) u_regbus (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .views     (views),
        .cmds      (cmds),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        any_pending = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++)
            any_pending = any_pending | (|pend_w[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_req <= 1'b0;
        else
            irq_req <= any_pending;
    end
endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk #(
    parameter int NB     = 2,
    parameter int ADDR_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic [NB-1:0][31:0]   ev,
    input logic [NB-1:0][31:0]   en,
    input logic [NB-1:0][31:0]   rise,
    input logic [NB-1:0][31:0]   pend,
    input logic                  irq_req
);
    // R1: reset keeps the request low
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq_req);

    // R2: the acknowledge offset never returns data
    a_r2_ack_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[3:0] == 4'h8) |-> (bus_rdata == 32'h0));

    // R10: request follows the pending words one edge later
    a_r10_req_rises: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> irq_req);
    a_r10_req_falls: assert property (@(posedge clk) disable iff (rst)
        !(|pend) |=> !irq_req);

    for (genvar b = 0; b < NB; b++) begin : g_bank_chk
        // R3: an enable write lands whole
        a_r3_enable_write: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == ADDR_W'(16*b + 4)) |=> (en[b] == $past(bus_wdata)));

        // R5 and R6: acknowledged bits clear unless an edge arrived with them
        a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == ADDR_W'(16*b + 8)) |=>
            ((ev[b] & $past(bus_wdata) & ~$past(rise[b] & en[b])) == 32'h0));

        // R4 and R7: an event bit is only set by a fresh edge on an enabled line
        a_r7_event_needs_edge: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ((ev[b] & ~$past(ev[b]) & ~$past(rise[b] & en[b])) == 32'h0));
    end
endmodule

bind banked_irq_ctrl irqc_chk #(.NB(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev        (ev_w),
    .en        (en_w),
    .rise      (rise_w),
    .pend      (pend_w),
    .irq_req   (irq_req)
);

// File: tb/banked_irq_ctrl_tb.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb;

    localparam logic [63:0] MASK2 = 64'h1ff0_0000_1ff0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;

    logic [31:0] irq1_in = '0;
    logic        b1_wr = 1'b0;
    logic [7:0]  b1_addr = '0;
    logic [31:0] b1_wdata = '0;
    logic [31:0] b1_rdata;
    logic        irq1_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    banked_irq_ctrl #(.NUM_BANKS(2), .ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    banked_irq_ctrl #(.NUM_BANKS(1), .ADDR_W(8)) u_dut1 (
        .clk(clk), .rst(rst), .irq_in(irq1_in), .bus_wr(b1_wr),
        .bus_addr(b1_addr), .bus_wdata(b1_wdata), .bus_rdata(b1_rdata),
        .irq_req(irq1_req)
    );

    // ---------------- behavioural reference for the two-bank build ----------
    logic [63:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_ev = '0, m_en = '0;
    logic        m_req = 1'b0;

    always @(posedge clk) begin
        logic [63:0] rise_v, ack_v, pend_v, en_n;
        int bank;
        bank   = int'(bus_addr[7:4]);
        rise_v = m_s2 & ~m_prev & m_en;
        pend_v = (m_ev | (m_s2 & MASK2)) & m_en;
        ack_v  = '0;
        en_n   = m_en;
        if (bus_wr && bus_addr[1:0] == 2'b00 && bank < 2) begin
            if (bus_addr[3:2] == 2'd2) ack_v = 64'(bus_wdata) << (32 * bank);
            if (bus_addr[3:2] == 2'd1) begin
                en_n = m_en & ~(64'hFFFF_FFFF << (32 * bank));
                en_n = en_n | (64'(bus_wdata) << (32 * bank));
            end
        end
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_ev = '0; m_en = '0; m_req = 1'b0;
        end else begin
            m_req  = |pend_v;
            m_ev   = (m_ev & ~ack_v) | rise_v;
            m_en   = en_n;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = irq_in;
        end
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        int bank;
        bank = int'(a[7:4]);
        if (a[1:0] != 2'b00 || bank >= 2) return 32'h0;
        case (a[3:2])
            2'd0:    return m_ev[32*bank +: 32];
            2'd1:    return m_en[32*bank +: 32];
            2'd3:    return m_s2[32*bank +: 32];
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R10 irq_req vs model", 32'(irq_req), 32'(m_req));
        chk("R2 bus_rdata vs model", bus_rdata, model_rd(bus_addr));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic wr1(input logic [7:0] a, input logic [31:0] d);
        b1_addr = a; b1_wdata = d; b1_wr = 1'b1;
        step();
        b1_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired, run hung");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        steps(3);
        rst = 1'b0;
        // R1: reset state
        rd_check(8'h00, 32'h0, "R1 event bank0");
        rd_check(8'h04, 32'h0, "R1 enable bank0");
        rd_check(8'h14, 32'h0, "R1 enable bank1");
        rd_check(8'h1C, 32'h0, "R1 level bank1");
        chk("R1 irq_req", 32'(irq_req), 32'h0);

        // R3 / R2: enable read-back, bank1 at 0x10
        wr(8'h04, 32'h0000_0003);
        rd_check(8'h04, 32'h0000_0003, "R3 enable bank0 readback");
        wr(8'h14, 32'h8000_0001);
        rd_check(8'h14, 32'h8000_0001, "R2 R3 enable bank1 readback");
        rd_check(8'h05, 32'h0, "R2 misaligned reads zero");
        rd_check(8'h24, 32'h0, "R2 unmapped bank reads zero");

        // R4: edge latency
        irq_in[0] = 1'b1;
        steps(2);
        rd_check(8'h00, 32'h0, "R4 event not yet set");
        step();
        rd_check(8'h00, 32'h1, "R4 event set after third edge");
        chk("R10 req lags event", 32'(irq_req), 32'h0);
        step();
        chk("R10 req follows event", 32'(irq_req), 32'h1);

        // R5: zeros ignored, ones clear; ack reads zero
        wr(8'h08, 32'hFFFF_FFFE);
        rd_check(8'h00, 32'h1, "R5 ack zero bit ignored");
        rd_check(8'h08, 32'h0, "R2 ack reads zero");
        wr(8'h08, 32'h0000_0001);
        rd_check(8'h00, 32'h0, "R5 ack one clears");
        step();
        chk("R10 req drops after ack", 32'(irq_req), 32'h0);

        // R6: edge and ack on the same edge
        irq_in[1] = 1'b1;
        steps(2);
        wr(8'h08, 32'h0000_0002);
        rd_check(8'h00, 32'h2, "R6 new edge beats ack");
        wr(8'h08, 32'h0000_0002);
        rd_check(8'h00, 32'h0, "R6 later ack clears");
        step();

        // R7: enabling an already high line
        irq_in[2] = 1'b1;
        steps(4);
        wr(8'h04, 32'h0000_0007);
        steps(3);
        rd_check(8'h00, 32'h0, "R7 no event on late enable");
        chk("R7 no request on late enable", 32'(irq_req), 32'h0);

        // R8: live levels
        irq_in[63:32] = 32'hA5A5_0F0F;
        steps(1);
        rd_check(8'h1C, 32'h0, "R8 level not yet visible");
        steps(1);
        rd_check(8'h1C, 32'hA5A5_0F0F, "R8 level bank1");
        rd_check(8'h0C, 32'h0000_0007, "R8 level bank0");
        steps(2);
        wr(8'h18, 32'hFFFF_FFFF);
        step();
        chk("R10 bank1 cleared", 32'(irq_req), 32'h0);

        // R9: level-type versus edge-type in the two-bank build
        irq_in[63:32] = 32'h0;
        steps(3);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h14, 32'h2010_0000);
        irq_in[52] = 1'b1;
        steps(4);
        chk("R9 level source requests", 32'(irq_req), 32'h1);
        wr(8'h18, 32'h0010_0000);
        steps(2);
        chk("R9 level-type holds after ack", 32'(irq_req), 32'h1);
        rd_check(8'h10, 32'h0, "R9 event cleared");
        irq_in[52] = 1'b0;
        steps(3);
        chk("R9 level drop clears request", 32'(irq_req), 32'h0);
        irq_in[61] = 1'b1;
        steps(4);
        chk("R9 edge source requests", 32'(irq_req), 32'h1);
        wr(8'h18, 32'h2000_0000);
        step();
        chk("R9 edge-type drops after ack", 32'(irq_req), 32'h0);

        // R11: clearing enables
        irq_in[52] = 1'b1;
        steps(4);
        chk("R11 request before disable", 32'(irq_req), 32'h1);
        wr(8'h04, 32'h0);
        wr(8'h14, 32'h0);
        step();
        chk("R11 request off after disable", 32'(irq_req), 32'h0);
        irq_in = ~irq_in;
        steps(4);
        chk("R11 stays off with toggling lines", 32'(irq_req), 32'h0);

        // R9 / R2: one-bank build, source 29 is level-type
        wr1(8'h04, 32'h2000_0000);
        irq1_in[29] = 1'b1;
        steps(4);
        chk("R9 one-bank request", 32'(irq1_req), 32'h1);
        wr1(8'h08, 32'h2000_0000);
        steps(2);
        chk("R9 one-bank level-type holds", 32'(irq1_req), 32'h1);
        b1_addr = 8'h14;
        #1;
        chk("R2 one-bank second bank reads zero", b1_rdata, 32'h0);

        // random phase, model compared every clock
        for (int i = 0; i < 600; i++) begin
            int r;
            irq_in = irq_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            r = $urandom_range(0, 9);
            if (r < 5) begin
                bus_addr  = {2'b00, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)),
                             ($urandom_range(0, 15) == 0) ? 2'b01 : 2'b00};
                bus_wdata = $urandom;
                bus_wr    = 1'b1;
            end else begin
                bus_addr  = {3'b000, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 2'b00};
                bus_wr    = 1'b0;
            end
            step();
        end
        bus_wr = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule